// File: doc/BRIEF.md
# I2C Master Read Byte Engine

This block is the read-direction half of an I2C master. It takes over the bus once the address phase is done. It clocks bytes in from SDA, most significant bit first, and moves each finished byte into a data register that software reads. On the ninth clock of every byte it pulls SDA low or leaves it released, according to a software acknowledge-enable level. That level is sampled as the eighth bit is captured. The engine raises a data-ready flag and, if software has fallen behind, a byte-finished flag. While byte-finished is set, it parks SCL low until the data register is read.

Software ends a read by clearing acknowledge-enable and posting a stop request right after it has read the second-last byte. The last byte then goes out with a not-acknowledge, and the stop follows straight after it. A repeated-start request works the same way. For a single-byte read, software clears acknowledge-enable while the address flag is still up, clears the flag to start the byte, and then posts the stop. Once the stop condition is on the bus, the engine drops its master-mode status and goes idle. SCL and SDA are reported as open-drain pull-down requests. An SCL half-period is a fixed number of core clocks.

Top module: `i2crx_engine`

## Requirements
- R1: Out of reset, both line pull-downs are off, the data register reads 0, and data-ready, byte-finished, address flag, master mode and the interrupt are all 0.
- R2: An address-done pulse in idle sets the address flag and master mode. While master mode is set in idle, both SCL and SDA are pulled low. An address-clear pulse while the flag is set clears it and starts the first byte on the next clock.
- R3: Each data bit holds SCL low for HALF_CLKS clocks and then releases it for HALF_CLKS clocks, with SDA released throughout. SDA is sampled on the last released clock, and the first bit sampled is bit 7 of the byte.
- R4: After the eighth bit comes a ninth clock of the same shape. SDA is held low for the whole of it (acknowledge) if acknowledge-enable was 1 on the clock that sampled the eighth bit, and left released (not-acknowledge) otherwise.
- R5: At the end of the ninth clock, if data-ready is 0 or is being read on that same clock, the byte goes into the data register and data-ready sets. The data register does not change while data-ready is set and no read is made.
- R6: A data read pulse while byte-finished is 0 clears data-ready.
- R7: If data-ready is still set when a byte ends, byte-finished sets and the data register keeps the older byte. SCL stays low with SDA released until a read pulse arrives. That read loads the held byte, clears byte-finished and leaves data-ready set.
- R8: After the ninth clock, SCL stays low for at least one clock. If the byte was acknowledged and no request is pending, the next byte's low half starts on the clock after byte-finished is 0 or is read.
- R9: After a not-acknowledged byte with no request pending, SCL stays low with SDA released until a stop or repeated-start request arrives.
- R10: A pending stop request runs once the hold is over and takes priority over a repeated-start request. It produces HALF_CLKS clocks of SCL low with SDA low, then HALF_CLKS clocks of SCL released with SDA low, then releases SDA and clears master mode.
- R11: A pending repeated-start request produces three steps of HALF_CLKS clocks each: SCL low with SDA released, then SCL released with SDA released, then SCL released with SDA low. The engine then returns to idle with both lines pulled low and master mode still set.
- R12: The interrupt equals event-enable AND (address flag OR byte-finished OR (buffer-enable AND data-ready)).
- R13: A single-byte read, with acknowledge-enable cleared while the address flag is set and a stop posted after the address clear, yields exactly one not-acknowledged byte, then a stop, with the byte left in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdaIn | input | 1 | Sensed SDA line level |
| addrDone | input | 1 | Pulse: address phase finished, take the bus |
| addrClr | input | 1 | Pulse: clear the address flag and start reading |
| ackEn | input | 1 | Acknowledge-enable level |
| stopReq | input | 1 | Pulse: request a stop condition |
| restartReq | input | 1 | Pulse: request a repeated start |
| dataRd | input | 1 | Pulse: software reads the data register |
| evtIrqEn | input | 1 | Event interrupt enable |
| bufIrqEn | input | 1 | Buffer interrupt enable |
| sclLow | output | 1 | Pull SCL low |
| sdaLow | output | 1 | Pull SDA low |
| rxData | output | DATA_BITS | Data register |
| rxNotEmpty | output | 1 | Data-ready flag |
| byteFinished | output | 1 | Byte-finished (overrun hold) flag |
| addrFlag | output | 1 | Address-sent flag |
| masterMode | output | 1 | Master mode status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with HALF_CLKS at 3 and DATA_BITS at 8. A whole byte then takes 54 clocks, so a four-byte read with a stop, an overrun hold, a not-acknowledge stall, a repeated start and a single-byte read all fit in a short run. With such a short half-period, an off-by-one in the phase counter or in the acknowledge sampling point moves a line edge by a large fraction of the phase, and the per-clock comparison against the behavioural model reports it at once.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_HOLD,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_RS_FALL
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;
    logic byteDone;
  } dpStrobe_t;

endpackage

// File: rtl/i2crx_ctrl.sv
module i2crx_ctrl
  import i2crx_pkg::*;
#(
  parameter int HALF_CLKS = 8,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrDone,
  input  logic      addrClr,
  input  logic      ackEn,
  input  logic      stopReq,
  input  logic      restartReq,
  input  logic      dataRd,
  input  logic      btf,
  output dpStrobe_t strobe,
  output logic      sclLow,
  output logic      sdaLow,
  output logic      addrFlag,
  output logic      masterMode
);

  localparam int CW    = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
  localparam int BIT_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0]    CNT_LAST = CW'(HALF_CLKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  rxState_e         state, stateNext;
  logic [CW-1:0]    cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             ackLatched;
  logic             stopPend, rsPend;
  logic             phaseEnd, lastBit, holdFree;
  logic             enterStop, enterRs, untimed;

  assign phaseEnd = (cnt == CNT_LAST);
  assign lastBit  = (bitIdx == BIT_LAST);
  assign holdFree = !btf || dataRd;
  assign untimed  = (state == ST_IDLE) || (state == ST_HOLD);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (!addrDone && addrClr && addrFlag) stateNext = ST_BIT_LO;
      ST_BIT_LO:  if (phaseEnd) stateNext = ST_BIT_HI;
      ST_BIT_HI:  if (phaseEnd) stateNext = lastBit ? ST_ACK_LO : ST_BIT_LO;
      ST_ACK_LO:  if (phaseEnd) stateNext = ST_ACK_HI;
      ST_ACK_HI:  if (phaseEnd) stateNext = ST_HOLD;
      ST_HOLD: begin
        if (holdFree) begin
          if (stopPend)        stateNext = ST_STOP_LO;
          else if (rsPend)     stateNext = ST_RS_LO;
          else if (ackLatched) stateNext = ST_BIT_LO;
        end
      end
      ST_STOP_LO: if (phaseEnd) stateNext = ST_STOP_HI;
      ST_STOP_HI: if (phaseEnd) stateNext = ST_IDLE;
      ST_RS_LO:   if (phaseEnd) stateNext = ST_RS_HI;
      ST_RS_HI:   if (phaseEnd) stateNext = ST_RS_FALL;
      ST_RS_FALL: if (phaseEnd) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign enterStop = (state == ST_HOLD) && (stateNext == ST_STOP_LO);
  assign enterRs   = (state == ST_HOLD) && (stateNext == ST_RS_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitIdx     <= '0;
      ackLatched <= 1'b0;
      stopPend   <= 1'b0;
      rsPend     <= 1'b0;
      addrFlag   <= 1'b0;
      masterMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state || untimed) cnt <= '0;
      else                               cnt <= cnt + 1'b1;

      if (state == ST_BIT_HI && phaseEnd) begin
        bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
        if (lastBit) ackLatched <= ackEn;
      end

      stopPend <= (stopPend & ~enterStop) | stopReq;
      rsPend   <= (rsPend & ~(enterRs | enterStop)) | restartReq;

      if (state == ST_IDLE) begin
        if (addrDone) begin
          addrFlag   <= 1'b1;
          masterMode <= 1'b1;
        end else if (addrClr) begin
          addrFlag <= 1'b0;
        end
      end
      if (state == ST_STOP_HI && phaseEnd) masterMode <= 1'b0;
    end
  end

  assign strobe.sampleBit = (state == ST_BIT_HI) && phaseEnd;
  assign strobe.byteDone  = (state == ST_ACK_HI) && phaseEnd;

  always_comb begin
    sclLow = 1'b1;
    sdaLow = 1'b0;
    unique case (state)
      ST_IDLE:    begin sclLow = masterMode; sdaLow = masterMode; end
      ST_BIT_LO:  begin sclLow = 1'b1; sdaLow = 1'b0;       end
      ST_BIT_HI:  begin sclLow = 1'b0; sdaLow = 1'b0;       end
      ST_ACK_LO:  begin sclLow = 1'b1; sdaLow = ackLatched; end
      ST_ACK_HI:  begin sclLow = 1'b0; sdaLow = ackLatched; end
      ST_HOLD:    begin sclLow = 1'b1; sdaLow = 1'b0;       end
      ST_STOP_LO: begin sclLow = 1'b1; sdaLow = 1'b1;       end
      ST_STOP_HI: begin sclLow = 1'b0; sdaLow = 1'b1;       end
      ST_RS_LO:   begin sclLow = 1'b1; sdaLow = 1'b0;       end
      ST_RS_HI:   begin sclLow = 1'b0; sdaLow = 1'b0;       end
      ST_RS_FALL: begin sclLow = 1'b0; sdaLow = 1'b1;       end
      default:    begin sclLow = 1'b1; sdaLow = 1'b0;       end
    endcase
  end

endmodule

// File: rtl/i2crx_dp.sv
module i2crx_dp
  import i2crx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaIn,
  input  logic                 dataRd,
  input  dpStrobe_t            strobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxNotEmpty,
  output logic                 byteFinished
);

  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      rxData       <= '0;
      rxNotEmpty   <= 1'b0;
      byteFinished <= 1'b0;
    end else begin
      if (strobe.sampleBit) shiftReg <= {shiftReg[DATA_BITS-2:0], sdaIn};

      if (strobe.byteDone) begin
        if (rxNotEmpty && !dataRd) begin
          byteFinished <= 1'b1;
        end else begin
          rxData     <= shiftReg;
          rxNotEmpty <= 1'b1;
        end
      end else if (dataRd) begin
        if (byteFinished) begin
          rxData       <= shiftReg;
          byteFinished <= 1'b0;
        end else begin
          rxNotEmpty <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/i2crx_engine.sv
module i2crx_engine
  import i2crx_pkg::*;
#(
  parameter int HALF_CLKS = 8,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaIn,
  input  logic                 addrDone,
  input  logic                 addrClr,
  input  logic                 ackEn,
  input  logic                 stopReq,
  input  logic                 restartReq,
  input  logic                 dataRd,
  input  logic                 evtIrqEn,
  input  logic                 bufIrqEn,
  output logic                 sclLow,
  output logic                 sdaLow,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxNotEmpty,
  output logic                 byteFinished,
  output logic                 addrFlag,
  output logic                 masterMode,
  output logic                 irq
);

  dpStrobe_t strobe;

  i2crx_ctrl #(.HALF_CLKS(HALF_CLKS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrDone   (addrDone),
    .addrClr    (addrClr),
    .ackEn      (ackEn),
    .stopReq    (stopReq),
    .restartReq (restartReq),
    .dataRd     (dataRd),
    .btf        (byteFinished),
    .strobe     (strobe),
    .sclLow     (sclLow),
    .sdaLow     (sdaLow),
    .addrFlag   (addrFlag),
    .masterMode (masterMode)
  );

  i2crx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sdaIn        (sdaIn),
    .dataRd       (dataRd),
    .strobe       (strobe),
    .rxData       (rxData),
    .rxNotEmpty   (rxNotEmpty),
    .byteFinished (byteFinished)
  );

  assign irq = evtIrqEn & (addrFlag | byteFinished | (bufIrqEn & rxNotEmpty));

endmodule

// File: rtl/i2crx_engine_chk.sv
module i2crx_engine_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dataRd,
  input logic                 sclLow,
  input logic                 sdaLow,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxNotEmpty,
  input logic                 byteFinished,
  input logic                 addrFlag,
  input logic                 masterMode
);

  // R7
  btf_implies_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteFinished |-> rxNotEmpty);

  // R7
  btf_parks_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteFinished |-> (sclLow && !sdaLow));

  // R7
  btf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteFinished && !dataRd) |=> byteFinished);

  // R5
  ready_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxNotEmpty) |-> !$past(sclLow));

  // R5
  data_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxNotEmpty && !dataRd) |=> $stable(rxData));

  // R10
  stop_then_slave_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(masterMode) |-> (!$past(sclLow) && $past(sdaLow) && !sdaLow));

  // R2
  addr_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrFlag |-> (sclLow && masterMode));

endmodule

bind i2crx_engine i2crx_engine_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .dataRd       (dataRd),
  .sclLow       (sclLow),
  .sdaLow       (sdaLow),
  .rxData       (rxData),
  .rxNotEmpty   (rxNotEmpty),
  .byteFinished (byteFinished),
  .addrFlag     (addrFlag),
  .masterMode   (masterMode)
);

// File: tb/i2crx_engine_bench.sv
`timescale 1ns/1ps
module i2crx_engine_bench;

  localparam int HALF = 3;
  localparam int P_IDLE = 0, P_DATA = 1, P_ACK = 2, P_WAIT = 3, P_STOP = 4, P_RS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrDone = 0, addrClr = 0, ackEn = 0, stopReq = 0, restartReq = 0, dataRd = 0;
  logic evtIrqEn = 0, bufIrqEn = 0;
  logic slaveLow = 1'b0;
  logic sdaIn;
  logic sclLow, sdaLow, rxNotEmpty, byteFinished, addrFlag, masterMode, irq;
  logic [7:0] rxData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign sdaIn = !(sdaLow | slaveLow);

  i2crx_engine #(.HALF_CLKS(HALF), .DATA_BITS(8)) u_i2crx_engine (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .addrDone(addrDone), .addrClr(addrClr),
    .ackEn(ackEn), .stopReq(stopReq), .restartReq(restartReq), .dataRd(dataRd),
    .evtIrqEn(evtIrqEn), .bufIrqEn(bufIrqEn), .sclLow(sclLow), .sdaLow(sdaLow),
    .rxData(rxData), .rxNotEmpty(rxNotEmpty), .byteFinished(byteFinished),
    .addrFlag(addrFlag), .masterMode(masterMode), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] slaveQ[$];
  bit         ackLog[$];
  int  mPhase, mHalf, mTick, mBit;
  bit  mAddr, mMaster, mAckL, mStopP, mRsP, mRxNe, mBtf, mByteEnd;
  logic [7:0] mByte, mPend, mData;

  task startByte();
    mPhase = P_DATA; mHalf = 0; mTick = 0; mBit = 0;
    mByte = (slaveQ.size() > 0) ? slaveQ.pop_front() : 8'hFF;
  endtask

  task enterPhase(input int ph);
    mPhase = ph; mHalf = 0; mTick = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = P_IDLE; mHalf = 0; mTick = 0; mBit = 0;
      mAddr = 0; mMaster = 0; mAckL = 0; mStopP = 0; mRsP = 0;
      mRxNe = 0; mBtf = 0; mByte = 0; mPend = 0; mData = 0;
    end else begin
      mByteEnd = 0;
      case (mPhase)
        P_IDLE: begin
          if (addrDone) begin mAddr = 1; mMaster = 1; end
          else if (addrClr && mAddr) begin mAddr = 0; startByte(); end
        end
        P_WAIT: begin
          if (!mBtf || dataRd) begin
            if (mStopP) begin mStopP = 0; mRsP = 0; enterPhase(P_STOP); end
            else if (mRsP) begin mRsP = 0; enterPhase(P_RS); end
            else if (mAckL) startByte();
          end
        end
        default: begin
          if (mTick == HALF - 1) begin
            mTick = 0;
            mHalf++;
            if (mHalf == ((mPhase == P_RS) ? 3 : 2)) begin
              case (mPhase)
                P_DATA: begin
                  if (mBit == 7) begin mAckL = ackEn; enterPhase(P_ACK); end
                  else begin mBit++; mHalf = 0; end
                end
                P_ACK:  begin mByteEnd = 1; mPhase = P_WAIT; end
                P_STOP: begin mMaster = 0; mPhase = P_IDLE; end
                default: mPhase = P_IDLE;
              endcase
            end
          end else begin
            mTick++;
          end
        end
      endcase
      if (mByteEnd) begin
        if (mRxNe && !dataRd) begin mBtf = 1; mPend = mByte; end
        else begin mData = mByte; mRxNe = 1; end
      end else if (dataRd) begin
        if (mBtf) begin mData = mPend; mBtf = 0; end
        else mRxNe = 0;
      end
      if (stopReq) mStopP = 1;
      if (restartReq) mRsP = 1;
    end
  end

  function automatic bit expScl();
    case (mPhase)
      P_IDLE: return mMaster;
      P_WAIT: return 1'b1;
      default: return (mHalf == 0);
    endcase
  endfunction

  function automatic bit expSda();
    case (mPhase)
      P_IDLE: return mMaster;
      P_ACK:  return mAckL;
      P_STOP: return 1'b1;
      P_RS:   return (mHalf == 2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string lineTag();
    case (mPhase)
      P_ACK:  return "R4";
      P_WAIT: return "R8";
      P_STOP: return "R10";
      P_RS:   return "R11";
      P_IDLE: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // slave drives its bit while SCL is low; per-clock comparison
  always @(negedge clk) begin
    slaveLow <= (rstN && mPhase == P_DATA) ? !mByte[7 - mBit] : 1'b0;
    if (rstN) begin
      if (mPhase == P_ACK && mHalf == 1 && mTick == 0) ackLog.push_back(sdaLow);
      chk(sclLow == expScl(), lineTag(), "sclLow", 32'(sclLow), 32'(expScl()));
      chk(sdaLow == expSda(), lineTag(), "sdaLow", 32'(sdaLow), 32'(expSda()));
      chk(rxNotEmpty == mRxNe, "R5", "rxNotEmpty", 32'(rxNotEmpty), 32'(mRxNe));
      chk(rxData == mData, "R5", "rxData", 32'(rxData), 32'(mData));
      chk(byteFinished == mBtf, "R7", "byteFinished", 32'(byteFinished), 32'(mBtf));
      chk(addrFlag == mAddr, "R2", "addrFlag", 32'(addrFlag), 32'(mAddr));
      chk(masterMode == mMaster, "R10", "masterMode", 32'(masterMode), 32'(mMaster));
      chk(irq == (evtIrqEn & (mAddr | mBtf | (bufIrqEn & mRxNe))), "R12", "irq",
          32'(irq), 32'(evtIrqEn & (mAddr | mBtf | (bufIrqEn & mRxNe))));
    end
  end

  // ---------------- stimulus helpers ----------------
  task tick();
    @(posedge clk);
    #1;
  endtask

  task pulseRead();   dataRd = 1;     tick(); dataRd = 0;     endtask
  task pulseStop();   stopReq = 1;    tick(); stopReq = 0;    endtask
  task pulseRs();     restartReq = 1; tick(); restartReq = 0; endtask
  task pulseAddr();   addrDone = 1;   tick(); addrDone = 0;   endtask
  task pulseClr();    addrClr = 1;    tick(); addrClr = 0;    endtask
  task waitReady();   while (!rxNotEmpty) tick(); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp1[4];
    bit ackExp[8];
    bit held;
    exp1 = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    ackExp = '{1, 1, 1, 0, 1, 1, 0, 0};

    repeat (5) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk(!sclLow && !sdaLow && rxData == 0 && !rxNotEmpty && !byteFinished && !addrFlag
        && !masterMode && !irq, "R1", "reset state", 32'({sclLow, sdaLow, rxNotEmpty,
        byteFinished, addrFlag, masterMode, irq}), 0);

    // ---- four-byte read, prompt reads, stop after second-last ----
    ackEn = 1; evtIrqEn = 1; bufIrqEn = 1;
    foreach (exp1[i]) slaveQ.push_back(exp1[i]);
    pulseAddr();
    chk(addrFlag && masterMode && sclLow && sdaLow, "R2", "address flag stretch",
        32'({addrFlag, masterMode, sclLow, sdaLow}), 32'hF);
    repeat (3) tick();
    pulseClr();
    chk(!addrFlag && sclLow && !sdaLow, "R2", "first bit low half",
        32'({addrFlag, sclLow, sdaLow}), 32'b010);
    for (int i = 0; i < 4; i++) begin
      waitReady();
      tick(); tick();
      chk(rxData == exp1[i], "R5", "byte value", 32'(rxData), 32'(exp1[i]));
      pulseRead();
      if (i == 2) begin
        ackEn = 0;
        pulseStop();
      end
    end
    while (masterMode) tick();
    chk(!sclLow && !sdaLow, "R10", "lines released after stop",
        32'({sclLow, sdaLow}), 0);

    // ---- overrun hold, acknowledged continue, nack stall, restart ----
    ackEn = 1;
    slaveQ.push_back(8'h11); slaveQ.push_back(8'h22); slaveQ.push_back(8'h33);
    pulseAddr();
    tick();
    pulseClr();
    while (!byteFinished) tick();
    chk(rxData == 8'h11 && rxNotEmpty, "R7", "older byte kept", 32'(rxData), 32'h11);
    held = 1;
    for (int i = 0; i < 20; i++) begin
      if (!(sclLow && !sdaLow && byteFinished)) held = 0;
      tick();
    end
    chk(held, "R7", "clock parked during overrun", 32'(held), 1);
    ackEn = 0;
    pulseRead();
    chk(rxData == 8'h22 && rxNotEmpty && !byteFinished, "R7", "held byte loaded",
        32'({rxNotEmpty, byteFinished, rxData}), 32'h222);
    for (int i = 1; i < HALF; i++) tick();
    chk(sclLow, "R8", "next byte low half", 32'(sclLow), 1);
    tick();
    chk(!sclLow, "R8", "next byte high half", 32'(sclLow), 0);
    pulseRead();
    chk(!rxNotEmpty, "R6", "read clears ready", 32'(rxNotEmpty), 0);
    waitReady();
    held = 1;
    for (int i = 0; i < 30; i++) begin
      if (!(sclLow && !sdaLow && masterMode)) held = 0;
      tick();
    end
    chk(held, "R9", "stall after nack", 32'(held), 1);
    chk(rxData == 8'h33, "R5", "last byte", 32'(rxData), 32'h33);
    pulseRead();
    pulseRs();
    repeat (3 * HALF + 4) tick();
    chk(sclLow && sdaLow && masterMode && !rxNotEmpty, "R11", "restart owns bus",
        32'({sclLow, sdaLow, masterMode, rxNotEmpty}), 32'b1110);

    // ---- single-byte read after restart ----
    slaveQ.push_back(8'h5A);
    pulseAddr();
    ackEn = 0;
    tick();
    pulseClr();
    pulseStop();
    while (masterMode) tick();
    chk(rxData == 8'h5A && rxNotEmpty, "R13", "single byte kept",
        32'({rxNotEmpty, rxData}), 32'h15A);
    chk(ackLog.size() > 0 && ackLog[ackLog.size()-1] == 0, "R13", "single byte nack",
        32'(ackLog.size()), 8);

    // ---- interrupt enables ----
    evtIrqEn = 1; bufIrqEn = 0; tick();
    chk(!irq, "R12", "buffer enable off", 32'(irq), 0);
    bufIrqEn = 1; tick();
    chk(irq, "R12", "both enables on", 32'(irq), 1);
    evtIrqEn = 0; tick();
    chk(!irq, "R12", "event enable off", 32'(irq), 0);
    pulseRead();
    chk(!rxNotEmpty, "R6", "read clears ready after stop", 32'(rxNotEmpty), 0);

    // R4 acknowledge pattern over all bytes
    chk(ackLog.size() == 8, "R4", "ack count", 32'(ackLog.size()), 8);
    for (int i = 0; i < 8 && i < ackLog.size(); i++)
      chk(ackLog[i] == ackExp[i], "R4", "ack pattern", 32'(ackLog[i]), 32'(ackExp[i]));

    repeat (4) tick();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule